// File: doc/BRIEF.md
# Two-Wide Register Rename Table with Mispredict Recovery

This block sits in the in-order front end of an out-of-order core. Each cycle it takes a group of up to two decoded instructions, in program order. For each one it receives two architectural source indices, a destination index and a flag that says whether the instruction writes a register. It returns the physical tags of the sources, a freshly allocated physical destination and the physical register the destination was mapped to before. The back end keeps that previous mapping for later use. Physical registers that are not in use wait in a first-in first-out free list.

The block holds two map tables. The speculative table is what renaming reads and writes. The committed table changes only through the commit port, which retires one register-writing instruction per cycle in program order. When an instruction retires, the physical register it displaced from the committed table goes back to the free list. A flush discards every instruction that has not committed. The committed table is copied over the speculative one, and the free list is rebuilt from the registers the committed table does not reference.

The group is accepted or stalled as a whole. Register zero always maps to physical zero and is never renamed.

Top module: `rn_rename_unit`

## Requirements
- R1: After reset, architectural register n maps to physical n in both tables. The free list holds P32 to P63, with P32 at its head.
- R2: A source tag is read from the speculative table. An allocating instruction takes the free-list head, and slot 0 takes its tag before slot 1. Slot 1 is the younger instruction.
- R3: An instruction with no destination, or whose destination is R0, allocates nothing. It reports destination tag 0 and previous tag 0. An R0 source always reads P0.
- R4: When slot 1 reads the register that slot 0 writes in the same group, the slot 1 source tag is slot 0's new tag.
- R5: The previous-tag output is the speculative mapping of the destination. When both slots write the same register, slot 1's previous tag is slot 0's new tag, and slot 1's mapping is the one kept.
- R6: The ready output is low when the free list holds fewer registers than the group needs. A group presented while ready is low changes no state.
- R7: A commit with destination index d and tag p writes p into entry d of the committed table. The tag that entry held before joins the free-list tail. A commit to R0 has no effect.
- R8: During a flush cycle, ready is low and no renaming happens. The flush discards every uncommitted instruction. Afterwards the speculative table equals the committed table, and the free list holds every unreferenced nonzero tag in ascending order.
- R9: A commit in the same cycle as a flush is applied to the committed table before that table is copied and the free list rebuilt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ren_vld_i | input | 2 | Slot valid, bit 0 is the older instruction |
| ren_hasdst_i | input | 2 | Slot writes a register |
| ren_dst_i | input | 2x5 | Destination architectural index per slot |
| ren_srca_i | input | 2x5 | First source architectural index per slot |
| ren_srcb_i | input | 2x5 | Second source architectural index per slot |
| ren_rdy_o | output | 1 | Group accepted this cycle |
| ren_pdst_o | output | 2x6 | New physical destination per slot |
| ren_pold_o | output | 2x6 | Previous physical mapping of the destination |
| ren_psrca_o | output | 2x6 | First source physical tag |
| ren_psrcb_o | output | 2x6 | Second source physical tag |
| cmt_vld_i | input | 1 | Commit one register-writing instruction |
| cmt_dst_i | input | 5 | Committed architectural destination |
| cmt_pdst_i | input | 6 | Committed physical tag |
| flush_i | input | 1 | Discard uncommitted state and restore from the committed table |

## Verification
The stimulus mixes random groups, sometimes with slot 1 reading or writing slot 0's destination, with no-destination and R0 instructions. These patterns separate in-group forwarding and same-destination ordering from plain table reads. An early phase with rare commits drains the free list, so stalls and the one-versus-two-register threshold are seen. Later phases commit often and flush at random, including flushes in the same cycle as a commit. Reallocated low-numbered tags then show that freed tags re-enter the list in the right order, and that rebuilds sort the list correctly.

// File: rtl/rn_pkg.sv
package rn_pkg;
  parameter int ARCH_N = 32;
  parameter int PHYS_N = 64;
  localparam int AW = $clog2(ARCH_N);
  localparam int PW = $clog2(PHYS_N);
  typedef logic [AW-1:0] areg_t;
  typedef logic [PW-1:0] preg_t;
  typedef logic [PW:0]   pcnt_t;
endpackage

// File: rtl/rn_free_fifo.sv
module rn_free_fifo
  import rn_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          pop_n_i,
  input  logic                push_i,
  input  preg_t               push_tag_i,
  input  logic                rebuild_i,
  input  logic [PHYS_N-1:0]   free_mask_i,
  output preg_t               head0_o,
  output preg_t               head1_o,
  output pcnt_t               count_o
);
  localparam int INIT_FREE = PHYS_N - ARCH_N;

  preg_t mem_q [PHYS_N];
  preg_t mem_d [PHYS_N];
  preg_t head_q, head_d, tail_q, tail_d;
  pcnt_t count_q, count_d;

  always_comb begin
    pcnt_t k;
    mem_d   = mem_q;
    head_d  = head_q;
    tail_d  = tail_q;
    count_d = count_q;
    k       = '0;
    if (rebuild_i) begin
      for (int p = 1; p < PHYS_N; p++) begin
        if (free_mask_i[p]) begin
          mem_d[k[PW-1:0]] = preg_t'(p);
          k = k + 1'b1;
        end
      end
      head_d  = '0;
      tail_d  = k[PW-1:0];
      count_d = k;
    end else begin
      if (push_i) mem_d[tail_q] = push_tag_i;
      tail_d  = tail_q + preg_t'(push_i);
      head_d  = head_q + preg_t'(pop_n_i);
      count_d = count_q + pcnt_t'(push_i) - pcnt_t'(pop_n_i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < PHYS_N; i++)
        mem_q[i] <= (i < INIT_FREE) ? preg_t'(ARCH_N + i) : '0;
      head_q  <= '0;
      tail_q  <= preg_t'(INIT_FREE);
      count_q <= pcnt_t'(INIT_FREE);
    end else begin
      mem_q   <= mem_d;
      head_q  <= head_d;
      tail_q  <= tail_d;
      count_q <= count_d;
    end
  end

  assign head0_o = mem_q[head_q];
  assign head1_o = mem_q[head_q + preg_t'(1)];
  assign count_o = count_q;

  p_no_underflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !rebuild_i |-> pcnt_t'(pop_n_i) <= count_q);
  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && !rebuild_i) |-> count_q < pcnt_t'(PHYS_N - 1));
endmodule

// File: rtl/rn_map_tables.sv
module rn_map_tables
  import rn_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        wr_en_i,
  input  areg_t             wr_idx_i [2],
  input  preg_t             wr_tag_i [2],
  input  logic              cmt_en_i,
  input  areg_t             cmt_idx_i,
  input  preg_t             cmt_tag_i,
  input  logic              flush_i,
  output preg_t             spec_o [ARCH_N],
  output preg_t             arch_o [ARCH_N],
  output logic [PHYS_N-1:0] free_mask_o
);
  preg_t spec_q [ARCH_N];
  preg_t spec_d [ARCH_N];
  preg_t arch_q [ARCH_N];
  preg_t arch_d [ARCH_N];

  always_comb begin
    arch_d = arch_q;
    if (cmt_en_i && cmt_idx_i != '0) arch_d[cmt_idx_i] = cmt_tag_i;
    spec_d = spec_q;
    if (flush_i) begin
      spec_d = arch_d;
    end else begin
      for (int s = 0; s < 2; s++)
        if (wr_en_i[s]) spec_d[wr_idx_i[s]] = wr_tag_i[s];
    end
    free_mask_o = '1;
    for (int a = 0; a < ARCH_N; a++) free_mask_o[arch_d[a]] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int a = 0; a < ARCH_N; a++) begin
        spec_q[a] <= preg_t'(a);
        arch_q[a] <= preg_t'(a);
      end
    end else begin
      spec_q <= spec_d;
      arch_q <= arch_d;
    end
  end

  assign spec_o = spec_q;
  assign arch_o = arch_q;

  p_zero_pinned_r3: assert property (@(posedge clk) disable iff (!rst_n)
    spec_q[0] == '0 && arch_q[0] == '0);
endmodule

// File: rtl/rn_rename_unit.sv
module rn_rename_unit
  import rn_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           ren_vld_i,
  input  logic [1:0]           ren_hasdst_i,
  input  logic [1:0][AW-1:0]   ren_dst_i,
  input  logic [1:0][AW-1:0]   ren_srca_i,
  input  logic [1:0][AW-1:0]   ren_srcb_i,
  output logic                 ren_rdy_o,
  output logic [1:0][PW-1:0]   ren_pdst_o,
  output logic [1:0][PW-1:0]   ren_pold_o,
  output logic [1:0][PW-1:0]   ren_psrca_o,
  output logic [1:0][PW-1:0]   ren_psrcb_o,
  input  logic                 cmt_vld_i,
  input  logic [AW-1:0]        cmt_dst_i,
  input  logic [PW-1:0]        cmt_pdst_i,
  input  logic                 flush_i
);
  preg_t spec_map [ARCH_N];
  preg_t arch_map [ARCH_N];
  logic [PHYS_N-1:0] free_mask;
  preg_t head0, head1;
  pcnt_t fl_count, need_cnt;
  logic [1:0] need, wr_en;
  logic [1:0] pop_n;
  areg_t wr_idx [2];
  preg_t wr_tag [2];
  logic fire, cmt_push;

  always_comb begin
    for (int s = 0; s < 2; s++)
      need[s] = ren_vld_i[s] && ren_hasdst_i[s] && (ren_dst_i[s] != '0);
    need_cnt  = pcnt_t'(need[0]) + pcnt_t'(need[1]);
    ren_rdy_o = !flush_i && (fl_count >= need_cnt);
    fire      = ren_rdy_o && (ren_vld_i != 2'b00);
    pop_n     = fire ? (2'(need[0]) + 2'(need[1])) : 2'd0;

    ren_pdst_o[0]  = need[0] ? head0 : '0;
    ren_pdst_o[1]  = need[1] ? (need[0] ? head1 : head0) : '0;

    ren_psrca_o[0] = spec_map[ren_srca_i[0]];
    ren_psrcb_o[0] = spec_map[ren_srcb_i[0]];
    ren_psrca_o[1] = (need[0] && ren_srca_i[1] == ren_dst_i[0]) ? ren_pdst_o[0]
                                                                 : spec_map[ren_srca_i[1]];
    ren_psrcb_o[1] = (need[0] && ren_srcb_i[1] == ren_dst_i[0]) ? ren_pdst_o[0]
                                                                 : spec_map[ren_srcb_i[1]];

    ren_pold_o[0]  = need[0] ? spec_map[ren_dst_i[0]] : '0;
    ren_pold_o[1]  = !need[1] ? '0 :
                     (need[0] && ren_dst_i[1] == ren_dst_i[0]) ? ren_pdst_o[0]
                                                              : spec_map[ren_dst_i[1]];

    for (int s = 0; s < 2; s++) begin
      wr_en[s]  = fire && need[s];
      wr_idx[s] = ren_dst_i[s];
      wr_tag[s] = ren_pdst_o[s];
    end
    cmt_push = cmt_vld_i && (cmt_dst_i != '0);
  end

  rn_map_tables u_maps (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en_i     (wr_en),
    .wr_idx_i    (wr_idx),
    .wr_tag_i    (wr_tag),
    .cmt_en_i    (cmt_vld_i),
    .cmt_idx_i   (cmt_dst_i),
    .cmt_tag_i   (cmt_pdst_i),
    .flush_i     (flush_i),
    .spec_o      (spec_map),
    .arch_o      (arch_map),
    .free_mask_o (free_mask)
  );

  rn_free_fifo u_free (
    .clk         (clk),
    .rst_n       (rst_n),
    .pop_n_i     (pop_n),
    .push_i      (cmt_push),
    .push_tag_i  (arch_map[cmt_dst_i]),
    .rebuild_i   (flush_i),
    .free_mask_i (free_mask),
    .head0_o     (head0),
    .head1_o     (head1),
    .count_o     (fl_count)
  );

  p_alloc_nonzero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && need[0]) |-> ren_pdst_o[0] != '0);
  p_alloc_distinct_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && need[0] && need[1]) |-> ren_pdst_o[0] != ren_pdst_o[1]);
  p_rebuild_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> fl_count == pcnt_t'(PHYS_N - ARCH_N));
  p_stall_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!ren_rdy_o && !cmt_vld_i && !flush_i) |=> $stable(fl_count));
endmodule

// File: tb/tb_rn_rename_unit.sv
module tb_rn_rename_unit;
  import rn_pkg::*;

  logic clk = 1'b0;
  logic rst_n;
  logic [1:0] ren_vld_i, ren_hasdst_i;
  logic [1:0][AW-1:0] ren_dst_i, ren_srca_i, ren_srcb_i;
  logic ren_rdy_o;
  logic [1:0][PW-1:0] ren_pdst_o, ren_pold_o, ren_psrca_o, ren_psrcb_o;
  logic cmt_vld_i;
  logic [AW-1:0] cmt_dst_i;
  logic [PW-1:0] cmt_pdst_i;
  logic flush_i;

  always #5 clk = ~clk;

  rn_rename_unit dut (.*);

  typedef struct { int a; int p; } ent_t;
  int spec[ARCH_N];
  int arch[ARCH_N];
  int fq[$];
  ent_t pend[$];
  int n_chk = 0, n_fail = 0;
  bit done = 0;
  bit last_flush_cmt = 0;

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    ren_vld_i = '0; ren_hasdst_i = '0; ren_dst_i = '0; ren_srca_i = '0; ren_srcb_i = '0;
    cmt_vld_i = 1'b0; cmt_dst_i = '0; cmt_pdst_i = '0; flush_i = 1'b0;
    for (int a = 0; a < ARCH_N; a++) begin spec[a] = a; arch[a] = a; end
    for (int p = ARCH_N; p < PHYS_N; p++) fq.push_back(p);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    for (int cyc = 0; cyc < 4000; cyc++) begin
      int n0, n1, erdy, ep0, ep1, d0, d1;
      string rq;
      bit cm;
      @(negedge clk);
      // stimulus
      if (cyc == 0) begin
        // R1/R4/R5: first group, same destination and forwarded source
        ren_vld_i = 2'b11; ren_hasdst_i = 2'b11;
        ren_dst_i[0] = 5; ren_dst_i[1] = 5;
        ren_srca_i[0] = 5; ren_srcb_i[0] = 0;
        ren_srca_i[1] = 5; ren_srcb_i[1] = 3;
        cmt_vld_i = 0; flush_i = 0;
      end else if (cyc == 1) begin
        // R3: destination R0 and no-destination slot
        ren_vld_i = 2'b11; ren_hasdst_i = 2'b01;
        ren_dst_i[0] = 0; ren_dst_i[1] = 7;
        ren_srca_i[0] = 0; ren_srcb_i[0] = 5;
        ren_srca_i[1] = 0; ren_srcb_i[1] = 5;
        cmt_vld_i = 0; flush_i = 0;
      end else begin
        int cprob;
        cprob = (cyc < 400) ? 8 : 55;
        ren_vld_i = 2'($urandom_range(0, 3));
        for (int s = 0; s < 2; s++) begin
          ren_hasdst_i[s] = ($urandom_range(0, 99) < 75);
          ren_dst_i[s]    = ($urandom_range(0, 9) == 0) ? '0 : AW'($urandom_range(1, ARCH_N - 1));
          ren_srca_i[s]   = AW'($urandom_range(0, ARCH_N - 1));
          ren_srcb_i[s]   = AW'($urandom_range(0, ARCH_N - 1));
        end
        if ($urandom_range(0, 9) < 3) ren_srca_i[1] = ren_dst_i[0];
        if ($urandom_range(0, 9) < 2) ren_srcb_i[1] = ren_dst_i[0];
        if ($urandom_range(0, 9) < 2) ren_dst_i[1]  = ren_dst_i[0];
        cmt_vld_i = (pend.size() > 0) && ($urandom_range(0, 99) < cprob);
        if (cmt_vld_i) begin
          cmt_dst_i  = AW'(pend[0].a);
          cmt_pdst_i = PW'(pend[0].p);
        end
        flush_i = (cyc >= 400) && ($urandom_range(0, 99) < 3);
      end
      #1;
      // expected values from the behavioural model
      d0 = int'(ren_dst_i[0]); d1 = int'(ren_dst_i[1]);
      n0 = (ren_vld_i[0] && ren_hasdst_i[0] && d0 != 0) ? 1 : 0;
      n1 = (ren_vld_i[1] && ren_hasdst_i[1] && d1 != 0) ? 1 : 0;
      erdy = (!flush_i && fq.size() >= n0 + n1) ? 1 : 0;
      chk(flush_i ? "R8" : "R6", int'(ren_rdy_o), erdy);
      if (erdy == 1) begin
        ep0 = n0 ? fq[0] : 0;
        ep1 = n1 ? (n0 ? fq[1] : fq[0]) : 0;
        rq = last_flush_cmt ? "R9" : "R2";
        if (ren_vld_i[0]) begin
          chk(cyc < 2 ? "R1" : (!n0 ? "R3" : (ep0 < ARCH_N ? "R7" : "R2")), int'(ren_pdst_o[0]), ep0);
          chk(rq, int'(ren_psrca_o[0]), spec[ren_srca_i[0]]);
          chk(rq, int'(ren_psrcb_o[0]), spec[ren_srcb_i[0]]);
          chk("R5", int'(ren_pold_o[0]), n0 ? spec[d0] : 0);
        end
        if (ren_vld_i[1]) begin
          chk(!n1 ? "R3" : (ep1 < ARCH_N ? "R7" : "R2"), int'(ren_pdst_o[1]), ep1);
          if (n0 && ren_srca_i[1] == ren_dst_i[0]) chk("R4", int'(ren_psrca_o[1]), ep0);
          else chk(rq, int'(ren_psrca_o[1]), spec[ren_srca_i[1]]);
          if (n0 && ren_srcb_i[1] == ren_dst_i[0]) chk("R4", int'(ren_psrcb_o[1]), ep0);
          else chk(rq, int'(ren_psrcb_o[1]), spec[ren_srcb_i[1]]);
          chk("R5", int'(ren_pold_o[1]), !n1 ? 0 : ((n0 && d1 == d0) ? ep0 : spec[d1]));
        end
        // model update for accepted group (R6: rejected groups change nothing)
        if (n0) begin void'(fq.pop_front()); spec[d0] = ep0; pend.push_back('{d0, ep0}); end
        if (n1) begin void'(fq.pop_front()); spec[d1] = ep1; pend.push_back('{d1, ep1}); end
      end
      // R7 commit
      cm = cmt_vld_i;
      if (cm) begin
        int ca, old;
        ca = int'(cmt_dst_i);
        void'(pend.pop_front());
        if (ca != 0) begin
          old = arch[ca];
          arch[ca] = int'(cmt_pdst_i);
          if (!flush_i) fq.push_back(old);
        end
      end
      // R8/R9 flush after commit
      last_flush_cmt = 0;
      if (flush_i) begin
        bit used[PHYS_N];
        for (int p = 0; p < PHYS_N; p++) used[p] = 0;
        for (int a = 0; a < ARCH_N; a++) begin spec[a] = arch[a]; used[arch[a]] = 1; end
        fq.delete();
        for (int p = 1; p < PHYS_N; p++) if (!used[p]) fq.push_back(p);
        pend.delete();
        last_flush_cmt = cm;
      end
    end
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule